// File: doc/BRIEF.md
# Segment Descriptor Loader and Checker

This block takes a 64-bit legacy segment descriptor together with the 16-bit selector that named it and, on a one-cycle load strobe, fills a hidden segment register. That register holds a 32-bit base, a 32-bit limit and a set of decoded attribute bits. The base and limit are reassembled from the fields that are split across the descriptor, and the limit is scaled when the granularity bit is set. The attribute bits cover privilege level, default operand size, and the code or data flavour.

A check-type input can add one of two validations to the load:
- a stack-segment check, used when a stack selector is loaded;
- a return-from-interrupt check, used when a return target code segment is loaded.

A failing check does not change the hidden register. Instead it reports one of these faults:
- a general protection fault, carrying the offending selector;
- a stack fault;
- a segment-not-present fault;
- a system-descriptor error.

A null selector is a no-load case. It raises a null flag and leaves the register untouched. All outcome flags are registered and stay valid until the next load. A `done_o` pulse marks the cycle in which they change.

Top module: `seg_desc_loader`

## Requirements
- R1: After a successful load, `base_o` equals descriptor bits 63:56 placed above descriptor bits 39:16.
- R2: After a successful load with granularity bit 55 clear, `limit_o` equals descriptor bits 51:48 placed above bits 15:0, zero-extended to 32 bits.
- R3: With bit 55 set, `limit_o` is the 20-bit raw limit shifted left by 12 with the low 12 bits all ones.
- R4: Bit 43 of the descriptor (type bit 3) set marks a code segment.
  - `readable_o` comes from bit 41, `conforming_o` from bit 42 and `long_o` from bit 53.
  - `writable_o` and `expdown_o` are 0.
  - `dpl_o` is bits 46:45 and `def32_o` is bit 54.
- R5: Bit 43 clear marks a data segment.
  - `writable_o` comes from bit 41 and `expdown_o` from bit 42.
  - `readable_o` is 1; `conforming_o` and `long_o` are 0, whatever bit 53 holds.
  - `dpl_o` and `def32_o` come from the same bits as in R4.
- R6: A selector is null when bits 15:2 are all zero (bits 1:0 are the RPL, bit 2 the table indicator). In the plain mode, and in the stack check when no protection fault applies, a null selector sets `null_o` and leaves base, limit and attributes unchanged.
- R7: In the plain mode (`chk_i` = 0), a non-null selector whose descriptor has S (bit 44) clear or present (bit 47) clear sets `sys_err_o` and loads nothing.
- R8: In the stack check (`chk_i` = 1), a null selector raises `gp_o` with `gp_code_o` equal to the selector, and loads nothing, if any of these holds:
  - `mode64_i` is 0;
  - `cpl_i` is 3;
  - the descriptor is not a writable data segment;
  - the DPL or the RPL differs from `cpl_i`.
- R9: In the stack check, a non-null selector with a non-present descriptor raises `ss_o` and loads nothing. A present data or code descriptor loads normally.
- R10: In the return check (`chk_i` = 2), `gp_o` is raised with the selector as `gp_code_o`, and nothing is loaded, if any of these holds:
  - the selector is null;
  - the RPL is below `cpl_i`;
  - the descriptor is not a code segment;
  - a non-conforming segment has DPL not equal to RPL;
  - a conforming segment has DPL above RPL.
- R11: In the return check, when no protection fault applies, a non-present descriptor raises `np_o` and loads nothing; otherwise the segment loads.
- R12: Outcome and register timing:
  - Results appear on the outputs one clock after the cycle in which `load_i` is high, and `done_o` pulses in that cycle.
  - The outcome flags and `gp_code_o` are replaced on every load, with at most one flag set, and `gp_code_o` is 0 unless `gp_o` is set.
  - All outputs hold while `load_i` is low.
  - Reset clears everything to zero.
- R13: Check code 3 behaves exactly as the plain mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load strobe, one cycle per descriptor |
| desc_i | input | 64 | Legacy segment descriptor |
| sel_i | input | 16 | Selector being loaded |
| cpl_i | input | 2 | Current privilege level |
| mode64_i | input | 1 | Processor is in 64-bit mode |
| chk_i | input | 2 | Check type: 0 plain, 1 stack, 2 return, 3 plain |
| base_o | output | 32 | Hidden segment base |
| limit_o | output | 32 | Hidden segment limit, scaled |
| dpl_o | output | 2 | Descriptor privilege level |
| def32_o | output | 1 | Default operand size is 32 bits |
| code_o | output | 1 | Segment is code |
| readable_o | output | 1 | Segment is readable |
| writable_o | output | 1 | Segment is writable |
| expdown_o | output | 1 | Data segment expands down |
| conforming_o | output | 1 | Code segment is conforming |
| long_o | output | 1 | Code segment runs in 64-bit mode |
| null_o | output | 1 | Last load used a null selector without fault |
| gp_o | output | 1 | Last load raised general protection |
| gp_code_o | output | 16 | Selector reported with general protection |
| ss_o | output | 1 | Last load raised a stack fault |
| np_o | output | 1 | Last load raised segment-not-present |
| sys_err_o | output | 1 | Last load met a system or absent descriptor |
| done_o | output | 1 | Pulses when results update |

## Verification
The assertions assume that the selector, descriptor, privilege level, mode flag and check code are valid and stable in the cycle in which `load_i` is high. They also assume that every load strobe is sampled at a clock edge after reset has been released. The bench drives every input on the falling edge and raises `load_i` for exactly one cycle per operation. It only changes the inputs while `load_i` is low, so each registered outcome can be traced to a single, complete set of inputs. All check codes, including the reserved one, are used, and the privilege values stay within two bits.

// File: rtl/seg_desc_pkg.sv
package seg_desc_pkg;

  typedef enum logic [1:0] {
    CHK_PLAIN = 2'd0,
    CHK_STACK = 2'd1,
    CHK_IRET  = 2'd2,
    CHK_RSVD  = 2'd3
  } chk_e;

  typedef enum logic [2:0] {
    V_LOAD = 3'd0,
    V_NULL = 3'd1,
    V_GP   = 3'd2,
    V_SS   = 3'd3,
    V_NP   = 3'd4,
    V_SYS  = 3'd5
  } verdict_e;

  typedef struct packed {
    logic [1:0] dpl;
    logic       def32;
    logic       code;
    logic       readable;
    logic       writable;
    logic       expdown;
    logic       conforming;
    logic       long_m;
  } seg_attr_t;

  // descriptor field positions
  localparam int unsigned D_LIM_LO_MSB  = 15;
  localparam int unsigned D_BASE_LO_LSB = 16;
  localparam int unsigned D_BASE_LO_MSB = 39;
  localparam int unsigned D_TYPE_LSB    = 40;
  localparam int unsigned D_TYPE_MSB    = 43;
  localparam int unsigned D_S_BIT       = 44;
  localparam int unsigned D_DPL_LSB     = 45;
  localparam int unsigned D_DPL_MSB     = 46;
  localparam int unsigned D_P_BIT       = 47;
  localparam int unsigned D_LIM_HI_LSB  = 48;
  localparam int unsigned D_LIM_HI_MSB  = 51;
  localparam int unsigned D_L_BIT       = 53;
  localparam int unsigned D_D_BIT       = 54;
  localparam int unsigned D_G_BIT       = 55;
  localparam int unsigned D_BASE_HI_LSB = 56;
  localparam int unsigned D_BASE_HI_MSB = 63;

endpackage

// File: rtl/seg_desc_unpack.sv
module seg_desc_unpack
  import seg_desc_pkg::*;
#(
  parameter int unsigned DESC_W     = 64,
  parameter int unsigned BASE_W     = 32,
  parameter int unsigned LIM_W      = 32,
  parameter int unsigned GRAN_SHIFT = 12
) (
  input  logic [DESC_W-1:0] desc_i,
  output logic [BASE_W-1:0] base_o,
  output logic [LIM_W-1:0]  limit_o,
  output seg_attr_t         attr_o,
  output logic              is_sys_o,
  output logic              present_o
);

  localparam int unsigned RAW_W = (D_LIM_HI_MSB - D_LIM_HI_LSB + 1) + (D_LIM_LO_MSB + 1);
  localparam int unsigned SCL_W = RAW_W + GRAN_SHIFT;

  logic [RAW_W-1:0] lim_raw;
  logic [SCL_W-1:0] lim_scl;
  logic [3:0]       typ;

  assign lim_raw = {desc_i[D_LIM_HI_MSB:D_LIM_HI_LSB], desc_i[D_LIM_LO_MSB:0]};
  assign lim_scl = {lim_raw, {GRAN_SHIFT{1'b1}}};
  assign typ     = desc_i[D_TYPE_MSB:D_TYPE_LSB];

  assign base_o    = BASE_W'({desc_i[D_BASE_HI_MSB:D_BASE_HI_LSB],
                              desc_i[D_BASE_LO_MSB:D_BASE_LO_LSB]});
  assign limit_o   = desc_i[D_G_BIT] ? LIM_W'(lim_scl) : LIM_W'(lim_raw);
  assign is_sys_o  = ~desc_i[D_S_BIT];
  assign present_o = desc_i[D_P_BIT];

  always_comb begin
    attr_o       = '0;
    attr_o.dpl   = desc_i[D_DPL_MSB:D_DPL_LSB];
    attr_o.def32 = desc_i[D_D_BIT];
    attr_o.code  = typ[3];
    if (typ[3]) begin
      attr_o.readable   = typ[1];
      attr_o.conforming = typ[2];
      attr_o.long_m     = desc_i[D_L_BIT];
    end else begin
      attr_o.readable = 1'b1;
      attr_o.writable = typ[1];
      attr_o.expdown  = typ[2];
    end
  end

endmodule

// File: rtl/seg_sel_check.sv
module seg_sel_check
  import seg_desc_pkg::*;
#(
  parameter int unsigned SEL_W = 16
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic [1:0]       cpl_i,
  input  logic             mode64_i,
  input  chk_e             chk_i,
  input  seg_attr_t        attr_i,
  input  logic             is_sys_i,
  input  logic             present_i,
  output verdict_e         verdict_o
);

  logic [1:0] rpl;
  logic       sel_null;
  logic       is_code;
  logic       is_wdata;
  logic       stk_gp;
  logic       ret_gp;

  assign rpl      = sel_i[1:0];
  assign sel_null = (sel_i[SEL_W-1:2] == '0);
  assign is_code  = ~is_sys_i & attr_i.code;
  assign is_wdata = ~is_sys_i & ~attr_i.code & attr_i.writable;

  assign stk_gp = ~mode64_i || (cpl_i == 2'd3) || ~is_wdata ||
                  (attr_i.dpl != cpl_i) || (rpl != cpl_i);

  assign ret_gp = sel_null || (rpl < cpl_i) || ~is_code ||
                  (~attr_i.conforming && (attr_i.dpl != rpl)) ||
                  ( attr_i.conforming && (attr_i.dpl > rpl));

  always_comb begin
    unique case (chk_i)
      CHK_STACK: begin
        if (sel_null)        verdict_o = stk_gp ? V_GP : V_NULL;
        else if (!present_i) verdict_o = V_SS;
        else if (is_sys_i)   verdict_o = V_SYS;
        else                 verdict_o = V_LOAD;
      end
      CHK_IRET: begin
        if (ret_gp)          verdict_o = V_GP;
        else if (!present_i) verdict_o = V_NP;
        else                 verdict_o = V_LOAD;
      end
      default: begin
        if (sel_null)                   verdict_o = V_NULL;
        else if (is_sys_i || !present_i) verdict_o = V_SYS;
        else                            verdict_o = V_LOAD;
      end
    endcase
  end

endmodule

// File: rtl/seg_desc_loader.sv
module seg_desc_loader
  import seg_desc_pkg::*;
#(
  parameter int unsigned DESC_W     = 64,
  parameter int unsigned SEL_W      = 16,
  parameter int unsigned BASE_W     = 32,
  parameter int unsigned LIM_W      = 32,
  parameter int unsigned GRAN_SHIFT = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DESC_W-1:0] desc_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [1:0]        cpl_i,
  input  logic              mode64_i,
  input  logic [1:0]        chk_i,
  output logic [BASE_W-1:0] base_o,
  output logic [LIM_W-1:0]  limit_o,
  output logic [1:0]        dpl_o,
  output logic              def32_o,
  output logic              code_o,
  output logic              readable_o,
  output logic              writable_o,
  output logic              expdown_o,
  output logic              conforming_o,
  output logic              long_o,
  output logic              null_o,
  output logic              gp_o,
  output logic [SEL_W-1:0]  gp_code_o,
  output logic              ss_o,
  output logic              np_o,
  output logic              sys_err_o,
  output logic              done_o
);

  logic [BASE_W-1:0] dec_base;
  logic [LIM_W-1:0]  dec_limit;
  seg_attr_t         dec_attr;
  logic              dec_sys;
  logic              dec_present;
  verdict_e          verdict;

  logic [BASE_W-1:0] base_q;
  logic [LIM_W-1:0]  limit_q;
  seg_attr_t         attr_q;
  logic [SEL_W-1:0]  gp_code_q;
  logic              null_q, gp_q, ss_q, np_q, sys_q, done_q;

  seg_desc_unpack #(
    .DESC_W     (DESC_W),
    .BASE_W     (BASE_W),
    .LIM_W      (LIM_W),
    .GRAN_SHIFT (GRAN_SHIFT)
  ) u_unpack (
    .desc_i    (desc_i),
    .base_o    (dec_base),
    .limit_o   (dec_limit),
    .attr_o    (dec_attr),
    .is_sys_o  (dec_sys),
    .present_o (dec_present)
  );

  seg_sel_check #(
    .SEL_W (SEL_W)
  ) u_check (
    .sel_i     (sel_i),
    .cpl_i     (cpl_i),
    .mode64_i  (mode64_i),
    .chk_i     (chk_e'(chk_i)),
    .attr_i    (dec_attr),
    .is_sys_i  (dec_sys),
    .present_i (dec_present),
    .verdict_o (verdict)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q    <= '0;
      limit_q   <= '0;
      attr_q    <= '0;
      gp_code_q <= '0;
      null_q    <= 1'b0;
      gp_q      <= 1'b0;
      ss_q      <= 1'b0;
      np_q      <= 1'b0;
      sys_q     <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= load_i;
      if (load_i) begin
        null_q    <= (verdict == V_NULL);
        gp_q      <= (verdict == V_GP);
        ss_q      <= (verdict == V_SS);
        np_q      <= (verdict == V_NP);
        sys_q     <= (verdict == V_SYS);
        gp_code_q <= (verdict == V_GP) ? sel_i : '0;
        if (verdict == V_LOAD) begin
          base_q  <= dec_base;
          limit_q <= dec_limit;
          attr_q  <= dec_attr;
        end
      end
    end
  end

  assign base_o       = base_q;
  assign limit_o      = limit_q;
  assign dpl_o        = attr_q.dpl;
  assign def32_o      = attr_q.def32;
  assign code_o       = attr_q.code;
  assign readable_o   = attr_q.readable;
  assign writable_o   = attr_q.writable;
  assign expdown_o    = attr_q.expdown;
  assign conforming_o = attr_q.conforming;
  assign long_o       = attr_q.long_m;
  assign null_o       = null_q;
  assign gp_o         = gp_q;
  assign gp_code_o    = gp_code_q;
  assign ss_o         = ss_q;
  assign np_o         = np_q;
  assign sys_err_o    = sys_q;
  assign done_o       = done_q;

  a_r12_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({null_o, gp_o, ss_o, np_o, sys_err_o}));

  a_r12_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable({base_o, limit_o, null_o, gp_o, ss_o, np_o, sys_err_o, gp_code_o}));

  a_r7_no_load_on_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && verdict != V_LOAD) |=> ($stable(base_o) && $stable(limit_o) && $stable(attr_q)));

  a_r8_gp_code_is_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (!gp_o || gp_code_o == $past(sel_i)));

  a_r3_gran_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && verdict == V_LOAD && desc_i[D_G_BIT]) |=> (&limit_o[GRAN_SHIFT-1:0]));

  a_r10_iret_null_gp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && chk_i == CHK_IRET && sel_i[SEL_W-1:2] == '0) |=> gp_o);

  a_r9_ss_only_stack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && chk_i != CHK_STACK) |=> !ss_o);

  a_r11_np_only_iret: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && chk_i != CHK_IRET) |=> !np_o);

endmodule

// File: tb/seg_desc_loader_tb.sv
module seg_desc_loader_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [63:0] desc = '0;
  logic [15:0] sel = '0;
  logic [1:0]  cpl = '0;
  logic        m64 = 1'b0;
  logic [1:0]  chk = '0;

  logic [31:0] base, limit;
  logic [1:0]  dpl;
  logic        def32, code, rd, wr, ed, conf, lng;
  logic        nul, gp, ss, np, syserr, done;
  logic [15:0] gp_code;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [4:0] ST_OK   = 5'b00000;
  localparam logic [4:0] ST_NULL = 5'b10000;
  localparam logic [4:0] ST_GP   = 5'b01000;
  localparam logic [4:0] ST_SS   = 5'b00100;
  localparam logic [4:0] ST_NP   = 5'b00010;
  localparam logic [4:0] ST_SYS  = 5'b00001;

  always #10 clk = ~clk;

  seg_desc_loader u_dut (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .desc_i(desc), .sel_i(sel),
    .cpl_i(cpl), .mode64_i(m64), .chk_i(chk),
    .base_o(base), .limit_o(limit), .dpl_o(dpl), .def32_o(def32), .code_o(code),
    .readable_o(rd), .writable_o(wr), .expdown_o(ed), .conforming_o(conf),
    .long_o(lng), .null_o(nul), .gp_o(gp), .gp_code_o(gp_code), .ss_o(ss),
    .np_o(np), .sys_err_o(syserr), .done_o(done)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(logic [31:0] b, logic [19:0] l, logic [3:0] t,
                                     logic s, logic [1:0] dp, logic p,
                                     logic lb, logic db, logic g);
    logic [63:0] d = '0;
    d[15:0]  = l[15:0];
    d[39:16] = b[23:0];
    d[43:40] = t;
    d[44]    = s;
    d[46:45] = dp;
    d[47]    = p;
    d[51:48] = l[19:16];
    d[53]    = lb;
    d[54]    = db;
    d[55]    = g;
    d[63:56] = b[31:24];
    return d;
  endfunction

  // {dpl,def32,code,rd,wr,ed,conf,long}
  function automatic logic [8:0] attr_v();
    return {dpl, def32, code, rd, wr, ed, conf, lng};
  endfunction

  function automatic logic [4:0] st_v();
    return {nul, gp, ss, np, syserr};
  endfunction

  task automatic apply(logic [63:0] d, logic [15:0] s, logic [1:0] c, logic m, logic [1:0] k);
    @(negedge clk);
    desc = d; sel = s; cpl = c; m64 = m; chk = k; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic t_reset();
    check("R12 reset base", base, 0);
    check("R12 reset limit", limit, 0);
    check("R12 reset attr", attr_v(), 0);
    check("R12 reset status", {st_v(), gp_code, done}, 0);
  endtask

  task automatic t_data();
    apply(mk(32'h12345678, 20'hABCDE, 4'b0110, 1, 2'd2, 1, 0, 1, 0), 16'h0013, 2'd0, 0, 2'd0);
    check("R12 done pulse", done, 1);
    check("R1 base", base, 32'h12345678);
    check("R2 limit", limit, 32'h000ABCDE);
    check("R5 data attr wr ed", attr_v(), {2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0});
    check("R12 status ok", st_v(), ST_OK);
    apply(mk(32'hFEDC0000, 20'h00001, 4'b0000, 1, 2'd0, 1, 1, 0, 0), 16'h0008, 2'd0, 0, 2'd0);
    check("R1 base 2", base, 32'hFEDC0000);
    check("R5 data read-only, L ignored", attr_v(), {2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0});
    @(negedge clk);
    check("R12 done one cycle", done, 0);
  endtask

  task automatic t_gran();
    apply(mk(32'h0, 20'h00012, 4'b0010, 1, 2'd0, 1, 0, 1, 1), 16'h0010, 2'd0, 0, 2'd0);
    check("R3 gran scale", limit, 32'h00012FFF);
    apply(mk(32'h0, 20'hFFFFF, 4'b0010, 1, 2'd0, 1, 0, 1, 1), 16'h0010, 2'd0, 0, 2'd0);
    check("R3 gran max", limit, 32'hFFFFFFFF);
    apply(mk(32'h0, 20'h00000, 4'b0010, 1, 2'd0, 1, 0, 1, 1), 16'h0010, 2'd0, 0, 2'd0);
    check("R3 gran zero", limit, 32'h00000FFF);
  endtask

  task automatic t_code();
    apply(mk(32'h00400000, 20'h0FFFF, 4'b1110, 1, 2'd3, 1, 1, 0, 0), 16'h0023, 2'd0, 0, 2'd0);
    check("R4 conforming readable long", attr_v(), {2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1});
    apply(mk(32'h00400000, 20'h0FFFF, 4'b1000, 1, 2'd1, 1, 0, 1, 0), 16'h0023, 2'd0, 0, 2'd0);
    check("R4 exec-only", attr_v(), {2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0});
  endtask

  task automatic t_null();
    apply(mk(32'hAAAA5555, 20'h01234, 4'b0010, 1, 2'd0, 1, 0, 1, 0), 16'h0018, 2'd0, 0, 2'd0);
    apply(mk(32'h11111111, 20'h00001, 4'b0010, 1, 2'd0, 1, 0, 1, 0), 16'h0003, 2'd0, 0, 2'd0);
    check("R6 null flag", st_v(), ST_NULL);
    check("R6 null keeps base", base, 32'hAAAA5555);
    check("R6 null keeps limit", limit, 32'h00001234);
    apply(mk(32'h11111111, 20'h00001, 4'b0010, 1, 2'd0, 1, 0, 1, 0), 16'h0004, 2'd0, 0, 2'd0);
    check("R6 table bit not null", {st_v(), base}, {ST_OK, 32'h11111111});
  endtask

  task automatic t_sys();
    apply(mk(32'h22222222, 20'h00002, 4'b0010, 0, 2'd0, 1, 0, 1, 0), 16'h0028, 2'd0, 0, 2'd0);
    check("R7 system desc", st_v(), ST_SYS);
    check("R7 system no load", base, 32'h11111111);
    apply(mk(32'h33333333, 20'h00002, 4'b0010, 1, 2'd0, 0, 0, 1, 0), 16'h0028, 2'd0, 0, 2'd0);
    check("R7 absent desc", {st_v(), base}, {ST_SYS, 32'h11111111});
  endtask

  task automatic t_stack_null();
    apply(mk(32'h44444444, 20'h0, 4'b0010, 1, 2'd2, 1, 0, 1, 0), 16'h0002, 2'd2, 1, 2'd1);
    check("R6 stack null accepted", {st_v(), gp_code, base}, {ST_NULL, 16'h0, 32'h11111111});
    apply(mk(32'h44444444, 20'h0, 4'b0010, 1, 2'd0, 1, 0, 1, 0), 16'h0000, 2'd0, 0, 2'd1);
    check("R8 not 64-bit", {st_v(), gp_code}, {ST_GP, 16'h0000});
    apply(mk(32'h44444444, 20'h0, 4'b0010, 1, 2'd3, 1, 0, 1, 0), 16'h0003, 2'd3, 1, 2'd1);
    check("R8 cpl3", {st_v(), gp_code}, {ST_GP, 16'h0003});
    apply(mk(32'h44444444, 20'h0, 4'b0000, 1, 2'd1, 1, 0, 1, 0), 16'h0001, 2'd1, 1, 2'd1);
    check("R8 not writable", {st_v(), gp_code}, {ST_GP, 16'h0001});
    apply(mk(32'h44444444, 20'h0, 4'b0010, 1, 2'd1, 1, 0, 1, 0), 16'h0000, 2'd0, 1, 2'd1);
    check("R8 dpl mismatch", {st_v(), gp_code}, {ST_GP, 16'h0000});
    apply(mk(32'h44444444, 20'h0, 4'b0010, 1, 2'd0, 1, 0, 1, 0), 16'h0001, 2'd0, 1, 2'd1);
    check("R8 rpl mismatch", {st_v(), gp_code, base}, {ST_GP, 16'h0001, 32'h11111111});
  endtask

  task automatic t_stack_np();
    apply(mk(32'h55555555, 20'h0, 4'b0010, 1, 2'd0, 0, 0, 1, 0), 16'h0010, 2'd0, 1, 2'd1);
    check("R9 stack absent", {st_v(), gp_code, base}, {ST_SS, 16'h0, 32'h11111111});
    apply(mk(32'h66666666, 20'h0, 4'b0010, 1, 2'd0, 1, 0, 1, 0), 16'h0010, 2'd0, 1, 2'd1);
    check("R9 stack present loads", {st_v(), base}, {ST_OK, 32'h66666666});
  endtask

  task automatic t_iret();
    apply(mk(32'h77777777, 20'h0, 4'b1010, 1, 2'd0, 1, 0, 1, 0), 16'h0000, 2'd0, 0, 2'd2);
    check("R10 null sel", {st_v(), gp_code}, {ST_GP, 16'h0000});
    apply(mk(32'h77777777, 20'h0, 4'b1010, 1, 2'd1, 1, 0, 1, 0), 16'h0009, 2'd2, 0, 2'd2);
    check("R10 rpl below cpl", {st_v(), gp_code}, {ST_GP, 16'h0009});
    apply(mk(32'h77777777, 20'h0, 4'b0010, 1, 2'd3, 1, 0, 1, 0), 16'h000B, 2'd0, 0, 2'd2);
    check("R10 data target", {st_v(), gp_code}, {ST_GP, 16'h000B});
    apply(mk(32'h77777777, 20'h0, 4'b1010, 1, 2'd2, 1, 0, 1, 0), 16'h000B, 2'd0, 0, 2'd2);
    check("R10 nonconf dpl!=rpl", {st_v(), gp_code}, {ST_GP, 16'h000B});
    apply(mk(32'h77777777, 20'h0, 4'b1110, 1, 2'd3, 1, 0, 1, 0), 16'h000A, 2'd0, 0, 2'd2);
    check("R10 conf dpl>rpl", {st_v(), gp_code, base}, {ST_GP, 16'h000A, 32'h66666666});
    apply(mk(32'h88888888, 20'h0, 4'b1110, 1, 2'd1, 1, 0, 1, 0), 16'h000A, 2'd2, 0, 2'd2);
    check("R10 conf dpl<rpl loads", {st_v(), gp_code, base}, {ST_OK, 16'h0, 32'h88888888});
    apply(mk(32'h99999999, 20'h0, 4'b1010, 1, 2'd3, 0, 0, 1, 0), 16'h000B, 2'd3, 0, 2'd2);
    check("R11 absent code", {st_v(), gp_code, base}, {ST_NP, 16'h0, 32'h88888888});
  endtask

  task automatic t_rsvd();
    apply(mk(32'h12121212, 20'h0, 4'b0010, 1, 2'd0, 0, 0, 1, 0), 16'h0010, 2'd0, 1, 2'd3);
    check("R13 absent as plain", {st_v(), base}, {ST_SYS, 32'h88888888});
    apply(mk(32'h12121212, 20'h0, 4'b0010, 1, 2'd0, 1, 0, 1, 0), 16'h0000, 2'd0, 1, 2'd3);
    check("R13 null as plain", st_v(), ST_NULL);
    apply(mk(32'h12121212, 20'h0, 4'b0010, 1, 2'd0, 1, 0, 1, 0), 16'h0010, 2'd0, 1, 2'd3);
    check("R13 loads as plain", {st_v(), base}, {ST_OK, 32'h12121212});
  endtask

  task automatic t_hold();
    apply(mk(32'h0, 20'h0, 4'b0010, 1, 2'd0, 1, 0, 1, 0), 16'h0005, 2'd0, 0, 2'd2);
    check("R12 gp before hold", {st_v(), gp_code}, {ST_GP, 16'h0005});
    @(negedge clk);
    desc = mk(32'hDEADBEEF, 20'h0, 4'b0010, 1, 2'd0, 1, 0, 1, 0);
    sel = 16'h0010; chk = 2'd0;
    repeat (3) @(negedge clk);
    check("R12 hold while idle", {st_v(), gp_code, base, done}, {ST_GP, 16'h0005, 32'h12121212, 1'b0});
    apply(desc, 16'h0010, 2'd0, 0, 2'd0);
    check("R12 status replaced", {st_v(), gp_code, base}, {ST_OK, 16'h0, 32'hDEADBEEF});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_data();
    t_gran();
    t_code();
    t_null();
    t_sys();
    t_stack_null();
    t_stack_np();
    t_iret();
    t_rsvd();
    t_hold();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule